// File: doc/BRIEF.md
# Interrupt Acceptance Gating Unit

This block sits between an interrupt priority resolver and the CPU sequencer. The resolver hands it one prioritised maskable request and a non-maskable request (NMI). The unit decides on which cycle one of them may be turned into exception processing. It issues a single-cycle accept pulse tagged as NMI or maskable. It then stays silent until the sequencer reports that it has finished taking the exception.

Three rules gate acceptance. First, an instruction that rewrites the interrupt-control register blocks acceptance at its own retirement boundary, so the following instruction always runs. Second, a block transfer in its byte-count variant holds off every request, NMI included, until it ends. Third, a word-count transfer holds off maskable requests but yields to NMI at the next transfer-cycle boundary. At that boundary the unit also tells the block mover to abort. The sequencer then stacks the address of the following instruction as the return address.

Requests are level-held by their sources and are checked again at every permitted slot.

Top module: `irq_accept_gate`

## Requirements
- R1: While rst_ni is low, and on the first sample after it, accept_o, accept_nmi_o and abort_xfer_o are all 0.
- R2: A maskable request (irq_req_i=1, nmi_req_i=0) at an instruction boundary (insn_bnd_i=1, inhib_insn_i=0, xfer_busy_i=0) gives accept_o=1 and accept_nmi_o=0 on the following cycle only.
- R3: At an instruction boundary with inhib_insn_i=1, no request is accepted. The next non-inhibiting boundary accepts the still-pending request.
- R4: Inhibiting boundaries chain: every boundary with inhib_insn_i=1 is blocked, whatever came before it.
- R5: While xfer_busy_i=1 with xfer_word_i=0 (byte-count variant), nothing is accepted, NMI included, whatever the boundary strobes do.
- R6: While xfer_busy_i=1 with xfer_word_i=1 (word-count variant), maskable requests are not accepted, and instruction-boundary strobes are ignored.
- R7: With xfer_busy_i=1, xfer_word_i=1 and nmi_req_i=1, accept_o, accept_nmi_o and abort_xfer_o are all 1 on the cycle after the first xfer_bnd_i=1. Nothing is accepted before that. abort_xfer_o tells the sequencer to stack the next instruction's address.
- R8: When both requests are pending at a permitted instruction boundary, the NMI is accepted (accept_nmi_o=1).
- R9: After an accept, no further accept is issued until ack_done_i=1 has been seen. Once it has, the next permitted slot accepts normally.
- R10: abort_xfer_o is 1 only together with an NMI accept, and accept_nmi_o is 1 only together with accept_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 1 | Prioritised maskable request, level |
| nmi_req_i | input | 1 | Non-maskable request, level |
| insn_bnd_i | input | 1 | Instruction retires this cycle |
| inhib_insn_i | input | 1 | Retiring instruction modifies the interrupt-control register |
| xfer_busy_i | input | 1 | Block transfer in progress |
| xfer_word_i | input | 1 | Transfer variant: 1 word-count, 0 byte-count |
| xfer_bnd_i | input | 1 | Transfer-cycle boundary strobe |
| ack_done_i | input | 1 | Sequencer finished taking the exception |
| accept_o | output | 1 | Accept pulse |
| accept_nmi_o | output | 1 | Accepted request is the NMI |
| abort_xfer_o | output | 1 | Abort the running block transfer |

## Verification
A stuck busy flag shows as a request that is never accepted after ack_done_i. A missing busy flag shows as a second accept pulse on the very next permitted slot. A wrong window decode shows one cycle after the offending strobe: an accept during a byte-count transfer, at an inhibiting boundary, or on a word-count transfer cycle that is not a boundary. A missing accept shows just as fast. A reference model in the bench checks all three outputs on every cycle, so any divergence is reported on the cycle it first appears.

// File: rtl/iag_pkg.sv
package iag_pkg;
  // slots opened in the current cycle
  typedef struct packed {
    logic open_mask;  // maskable may be taken
    logic open_nmi;   // nmi may be taken
    logic xfer_slot;  // nmi slot inside a word-count transfer
  } win_t;

  typedef enum logic [1:0] {
    TAKE_NONE = 2'd0,
    TAKE_IRQ  = 2'd1,
    TAKE_NMI  = 2'd2
  } take_e;
endpackage

// File: rtl/iag_window.sv
module iag_window
  import iag_pkg::*;
(
  input  logic insn_bnd_i,
  input  logic inhib_insn_i,
  input  logic xfer_busy_i,
  input  logic xfer_word_i,
  input  logic xfer_bnd_i,
  output win_t win_o
);
  logic insn_ok;
  logic word_bnd;

  // instruction boundaries do not count while a transfer owns the sequencer
  assign insn_ok  = insn_bnd_i & ~inhib_insn_i & ~xfer_busy_i;
  assign word_bnd = xfer_busy_i & xfer_word_i & xfer_bnd_i;

  always_comb begin
    win_o.open_mask = insn_ok;
    win_o.open_nmi  = insn_ok | word_bnd;
    win_o.xfer_slot = word_bnd;
  end
endmodule

// File: rtl/iag_arbiter.sv
module iag_arbiter
  import iag_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  win_t win_i,
  input  logic irq_req_i,
  input  logic nmi_req_i,
  input  logic ack_done_i,
  output logic accept_o,
  output logic accept_nmi_o,
  output logic abort_xfer_o
);
  take_e take;
  logic  busy_q;

  always_comb begin
    take = TAKE_NONE;
    if (!busy_q) begin
      if (nmi_req_i && win_i.open_nmi)       take = TAKE_NMI;
      else if (irq_req_i && win_i.open_mask) take = TAKE_IRQ;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      accept_o     <= 1'b0;
      accept_nmi_o <= 1'b0;
      abort_xfer_o <= 1'b0;
    end else begin
      accept_o     <= (take != TAKE_NONE);
      accept_nmi_o <= (take == TAKE_NMI);
      abort_xfer_o <= (take == TAKE_NMI) && win_i.xfer_slot;
      if (take != TAKE_NONE) busy_q <= 1'b1;
      else if (ack_done_i)   busy_q <= 1'b0;
    end
  end

  // R9
  pulse_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !accept_o);
  // R9
  hold_until_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ack_done_i) |=> !accept_o);
endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
  import iag_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_req_i,
  input  logic nmi_req_i,
  input  logic insn_bnd_i,
  input  logic inhib_insn_i,
  input  logic xfer_busy_i,
  input  logic xfer_word_i,
  input  logic xfer_bnd_i,
  input  logic ack_done_i,
  output logic accept_o,
  output logic accept_nmi_o,
  output logic abort_xfer_o
);
  win_t win;

  iag_window u_window (
    .insn_bnd_i  (insn_bnd_i),
    .inhib_insn_i(inhib_insn_i),
    .xfer_busy_i (xfer_busy_i),
    .xfer_word_i (xfer_word_i),
    .xfer_bnd_i  (xfer_bnd_i),
    .win_o       (win)
  );

  iag_arbiter u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_i       (win),
    .irq_req_i   (irq_req_i),
    .nmi_req_i   (nmi_req_i),
    .ack_done_i  (ack_done_i),
    .accept_o    (accept_o),
    .accept_nmi_o(accept_nmi_o),
    .abort_xfer_o(abort_xfer_o)
  );

  // R3
  inhib_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_bnd_i && inhib_insn_i && !xfer_busy_i) |=> !accept_o);
  // R5
  byte_xfer_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_busy_i && !xfer_word_i) |=> !accept_o);
  // R6
  word_xfer_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_busy_i && xfer_word_i) |=> !(accept_o && !accept_nmi_o));
  // R7
  word_xfer_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_busy_i && !xfer_bnd_i) |=> !accept_o);
  // R10
  abort_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_xfer_o |-> (accept_nmi_o && accept_o));
  // R10
  nmi_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_nmi_o |-> accept_o);
endmodule

// File: tb/sim_irq_accept_gate.sv
module sim_irq_accept_gate;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic irq, nmi, ib, inh, xb, xw, xbd, ack;
  logic acc, acc_nmi, abrt;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // reference state
  bit m_busy = 0;
  bit e_acc = 0, e_nmi = 0, e_abrt = 0;

  always #4 clk = ~clk;

  irq_accept_gate u0 (
    .clk_i(clk), .rst_ni(rst_ni), .irq_req_i(irq), .nmi_req_i(nmi),
    .insn_bnd_i(ib), .inhib_insn_i(inh), .xfer_busy_i(xb), .xfer_word_i(xw),
    .xfer_bnd_i(xbd), .ack_done_i(ack),
    .accept_o(acc), .accept_nmi_o(acc_nmi), .abort_xfer_o(abrt)
  );

  task automatic compare();
    n_cmp++;
    if ({acc, acc_nmi, abrt} !== {e_acc, e_nmi, e_abrt}) begin
      n_bad++;
      $display("FAIL %s t=%0t acc/nmi/abort actual=%b%b%b expected=%b%b%b",
               cur_req, $time, acc, acc_nmi, abrt, e_acc, e_nmi, e_abrt);
    end
  endtask

  // drive one cycle of inputs, predict, then check on the next negedge
  task automatic cyc(bit b_ib, bit b_inh, bit b_xb, bit b_xw, bit b_xbd,
                     bit b_nmi, bit b_irq, bit b_ack);
    bit slot_ok, nmi_ok, got_n, got_i;
    ib = b_ib; inh = b_inh; xb = b_xb; xw = b_xw; xbd = b_xbd;
    nmi = b_nmi; irq = b_irq; ack = b_ack;
    // rules read straight from the requirements
    slot_ok = b_ib && !b_inh && !b_xb;               // R2 R3 R6
    nmi_ok  = slot_ok || (b_xb && b_xw && b_xbd);    // R5 R7
    got_n   = !m_busy && b_nmi && nmi_ok;            // R8 R9
    got_i   = !m_busy && b_irq && slot_ok && !got_n;
    e_acc  = got_n || got_i;
    e_nmi  = got_n;
    e_abrt = got_n && b_xb;
    if (got_n || got_i) m_busy = 1;
    else if (b_ack)     m_busy = 0;
    @(negedge clk);
    compare();
  endtask

  initial begin : watchdog
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    {irq, nmi, ib, inh, xb, xw, xbd, ack} = '0;
    // R1 reset state
    cur_req = "R1";
    repeat (2) begin @(negedge clk); compare(); end
    rst_ni = 1'b1;
    cyc(0,0,0,0,0,0,0,0);

    // R2 plain maskable accept, then ack
    cur_req = "R2";
    cyc(0,0,0,0,0,0,1,0);
    cyc(1,0,0,0,0,0,1,0);
    cyc(0,0,0,0,0,0,0,1);
    cyc(0,0,0,0,0,0,0,0);

    // R3 inhibiting boundary blocks, next one accepts held request
    cur_req = "R3";
    cyc(1,1,0,0,0,0,1,0);
    cyc(0,0,0,0,0,0,1,0);
    cyc(1,0,0,0,0,0,1,0);
    cyc(0,0,0,0,0,0,0,1);

    // R4 chained inhibits
    cur_req = "R4";
    cyc(1,1,0,0,0,1,0,0);
    cyc(1,1,0,0,0,1,0,0);
    cyc(1,1,0,0,0,1,0,0);
    cyc(1,0,0,0,0,1,0,0);
    cyc(0,0,0,0,0,0,0,1);

    // R5 byte-count transfer blocks NMI too
    cur_req = "R5";
    for (int i = 0; i < 6; i++) cyc(i[0], 0, 1, 0, 1, 1, 1, 0);
    cyc(1,0,0,0,0,1,1,0);      // ends: NMI wins (R8 also)
    cyc(0,0,0,0,0,0,0,1);

    // R6 word-count transfer holds maskable
    cur_req = "R6";
    for (int i = 0; i < 5; i++) cyc(1, 0, 1, 1, i[0], 0, 1, 0);
    cyc(1,0,0,0,0,0,1,0);
    cyc(0,0,0,0,0,0,0,1);

    // R7 NMI breaks word-count transfer only at a transfer-cycle boundary
    cur_req = "R7";
    cyc(0,0,1,1,0,1,1,0);
    cyc(1,0,1,1,0,1,1,0);
    cyc(0,0,1,1,1,1,1,0);
    cyc(0,0,0,0,0,0,0,1);

    // R8 priority at a normal boundary
    cur_req = "R8";
    cyc(1,0,0,0,0,1,1,0);
    cyc(0,0,0,0,0,0,0,1);

    // R9 no second accept before ack_done
    cur_req = "R9";
    cyc(1,0,0,0,0,0,1,0);
    for (int i = 0; i < 4; i++) cyc(1,0,0,0,0,1,1,0);
    cyc(0,0,0,0,0,1,1,1);
    cyc(1,0,0,0,0,0,1,0);
    cyc(0,0,0,0,0,0,0,1);

    // R10 and a mixed pseudo-random run covering R3 R5 R7 R9
    cur_req = "R10";
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom;
      cyc(r[0], r[1] & r[2], r[3] & r[4], r[5], r[6], r[7] & r[8],
          r[9], r[10] & r[11]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule